// File: doc/BRIEF.md
# Serial Audio Slot Receiver

This block captures two-channel serial audio from an external source that drives the bit clock, word-select and data lines. It samples those three lines in the system clock domain and finds the rising edges of the bit clock. It cuts the data stream into channel slots at each word-select transition and turns the bits of each slot into one sample word. Each finished word, together with a flag that says which channel it belongs to, is offered on a valid/ready output toward a receive FIFO.

A 32-bit configuration word is sampled on every clock. Its low bits set the run control, a receiver reset, an output flush, stereo or mono capture, the word-select polarity, MSB-first or LSB-first order, left or right justification, sign-widening of samples, and one of three stop policies. The output obeys valid/ready rules:
- A word is presented with `out_valid` and stays unchanged until `out_ready` is seen high on a clock edge.
- A low `out_ready` while a word is held counts as a full FIFO.
- A sample that completes while the FIFO is full is dropped.

Top module: `i2s_slot_rx`

## Requirements
- R1: The data line is sampled on rising bit-clock edges. The bit sampled on the edge where word-select is first seen changed is the last bit of the current slot, and the next bit starts a new slot. A slot is delivered only if it began with such a change while reception was active, so the partial slot in progress at start is discarded.
- R2: With `ws_pol` (bit 5) at 0, word-select low marks the left channel. With `ws_pol` at 1, word-select high marks the left channel. `out_right` is 0 for the left channel and 1 for the right channel.
- R3: With `lsb_first` (bit 6) at 0, the first sample bit on the line is the sample MSB. With `lsb_first` at 1, the first sample bit is the sample LSB.
- R4: With `left_just` (bit 7) at 1, the sample is the first SAMPLE_W bits of the slot. With `left_just` at 0, the sample is the last SAMPLE_W bits. All other slot bits are ignored.
- R5: With `mono` (bit 3) at 1, only one channel is delivered. It is the left channel when `mono_first` (bit 4) is 1 and the right channel when `mono_first` is 0. With `mono` at 0, both channels are delivered in order.
- R6: With `fill_wide` (bit 8) at 1, the sample is sign-extended to the 32-bit output. With `fill_wide` at 0, it is zero-extended.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_right` hold their values.
- R8: In stop modes 0, 1 and 3 (bits 10:9), a sample completing while the FIFO is full is dropped and `rx_overflow` is set. The flag stays set until a flush.
- R9: In stop mode 1, a high `eof_in` while active ends reception on the next clock.
- R10: In stop mode 2, a full FIFO while active ends reception on the next clock. A dropped sample does not set `rx_overflow` in this mode.
- R11: Reception becomes active one clock after `run` (bit 0) is seen rising from 0 to 1. It ends when `run` is 0. After any stop, `run` must return to 0 before reception can restart. After reset the block is idle and delivers nothing.
- R12: While `rx_rst` (bit 1) is set, reception is inactive and the slot state is cleared.
- R13: Setting `flush` (bit 2) discards the held output word and clears `rx_overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 32 | Configuration word, sampled every clock |
| bclk_in | input | 1 | Serial bit clock from the source |
| ws_in | input | 1 | Word-select line |
| sd_in | input | 1 | Serial data line |
| eof_in | input | 1 | End-of-frame indication used by stop mode 1 |
| out_data | output | OUT_W | Sample word toward the FIFO |
| out_right | output | 1 | 1 when the word is from the right channel |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | FIFO can accept the word |
| rx_active | output | 1 | Reception is running |
| rx_overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench goes after the slot boundary: a receiver that frames one bit early or late delivers samples shifted by one place, and one that trusts the slot already in progress at start delivers a garbage first word. It sweeps polarity, bit order and mono selection together with both justifications and both fill settings. Swapped channel tags, reversed bits, misplaced justification windows or the wrong extension would each show up as a mismatch against the expected queue. It holds back `out_ready` in two ways:
- Under stop mode 0, a design that overwrites the held word or forgets the overflow flag is caught.
- Under stop mode 2, a design that keeps receiving, or wrongly flags overflow, is caught.

It also checks that end-of-frame stops, resets and flushes take effect, and that reception does not restart until `run` is toggled.

// File: rtl/i2s_slot_rx_pkg.sv
package i2s_slot_rx_pkg;

  typedef enum logic [1:0] {
    STOP_MANUAL  = 2'd0,
    STOP_ON_EOF  = 2'd1,
    STOP_ON_FULL = 2'd2,
    STOP_RSVD    = 2'd3
  } stop_mode_e;

  typedef struct packed {
    stop_mode_e stop_mode;
    logic       fill_wide;
    logic       left_just;
    logic       lsb_first;
    logic       ws_pol;
    logic       mono_first;
    logic       mono;
    logic       flush;
    logic       rx_rst;
    logic       run;
  } rx_cfg_t;

  localparam int CFG_USED = $bits(rx_cfg_t);

  // idle, left-justified, first channel kept in mono
  localparam logic [CFG_USED-1:0] CFG_RESET = 11'h090;

endpackage

// File: rtl/i2s_slot_rx_sync.sv
module i2s_slot_rx_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic             rise0
);

  logic [STAGES-1:0] chain [LINES];
  logic              prev0;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= {chain[g][STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[g][STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev0 <= 1'b0;
    else        prev0 <= dout[0];
  end

  assign rise0 = dout[0] & ~prev0;

endmodule

// File: rtl/i2s_slot_rx_deser.sv
module i2s_slot_rx_deser #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                active,
  input  logic                tick,
  input  logic                ws,
  input  logic                sd,
  input  logic                lsb_first,
  input  logic                left_just,
  input  logic                ws_pol,
  output logic                emit_v,
  output logic                emit_right,
  output logic [SAMPLE_W-1:0] emit_sample
);

  localparam int CW = $clog2(SLOT_W + 1);

  logic [CW-1:0]       cnt;
  logic [SAMPLE_W-1:0] sr, sr_next;
  logic                ws_q, have_ws, slot_ok, slot_ws;
  logic                bound, shift_en;

  // a word-select change closes the slot on this very bit
  assign bound    = tick && have_ws && (ws != ws_q);
  assign shift_en = !left_just || (cnt < CW'(SAMPLE_W));

  always_comb begin
    sr_next = sr;
    if (shift_en) begin
      if (lsb_first) sr_next = {sd, sr[SAMPLE_W-1:1]};
      else           sr_next = {sr[SAMPLE_W-2:0], sd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      sr          <= '0;
      ws_q        <= 1'b0;
      have_ws     <= 1'b0;
      slot_ok     <= 1'b0;
      slot_ws     <= 1'b0;
      emit_v      <= 1'b0;
      emit_right  <= 1'b0;
      emit_sample <= '0;
    end else begin
      emit_v <= 1'b0;
      if (clr) begin
        cnt     <= '0;
        sr      <= '0;
        have_ws <= 1'b0;
        slot_ok <= 1'b0;
      end else begin
        if (tick) begin
          ws_q    <= ws;
          have_ws <= 1'b1;
          if (bound) begin
            emit_v      <= slot_ok && active;
            emit_sample <= sr_next;
            emit_right  <= slot_ws ^ ws_pol;
            sr          <= '0;
            cnt         <= '0;
            slot_ok     <= active;
            slot_ws     <= ws;
          end else begin
            sr <= sr_next;
            if (cnt != CW'(SLOT_W)) cnt <= cnt + 1'b1;
          end
        end
        if (!active) slot_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2s_slot_rx_ctrl.sv
module i2s_slot_rx_ctrl
  import i2s_slot_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rx_rst,
  input  stop_mode_e stop_mode,
  input  logic       eof,
  input  logic       full,
  output logic       active
);

  logic run_q, stop_hit;

  always_comb begin
    unique case (stop_mode)
      STOP_ON_EOF:  stop_hit = eof;
      STOP_ON_FULL: stop_hit = full;
      default:      stop_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      active <= 1'b0;
    end else begin
      run_q <= run;
      if (rx_rst || !run)        active <= 1'b0;
      else if (!run_q)           active <= 1'b1;
      else if (active && stop_hit) active <= 1'b0;
    end
  end

endmodule

// File: rtl/i2s_slot_rx_out.sv
module i2s_slot_rx_out
  import i2s_slot_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int OUT_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                emit_v,
  input  logic                emit_right,
  input  logic [SAMPLE_W-1:0] emit_sample,
  input  logic                mono,
  input  logic                mono_first,
  input  logic                fill_wide,
  input  stop_mode_e          stop_mode,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_right,
  output logic                overflow,
  output logic                full
);

  localparam int PAD_W = OUT_W - SAMPLE_W;

  logic [OUT_W-1:0] word;
  logic             keep, take, slot_free;

  if (PAD_W == 0) begin : g_nopad
    assign word = emit_sample;
  end else begin : g_pad
    assign word = {{PAD_W{fill_wide & emit_sample[SAMPLE_W-1]}}, emit_sample};
  end

  assign keep      = !mono || (emit_right == !mono_first);
  assign take      = emit_v && keep;
  assign slot_free = !out_valid || out_ready;
  assign full      = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_right <= 1'b0;
      overflow  <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (take && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= word;
        out_right <= emit_right;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (take && !slot_free && stop_mode != STOP_ON_FULL) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/i2s_slot_rx.sv
module i2s_slot_rx
  import i2s_slot_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int OUT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_word,
  input  logic             bclk_in,
  input  logic             ws_in,
  input  logic             sd_in,
  input  logic             eof_in,
  output logic [OUT_W-1:0] out_data,
  output logic             out_right,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             rx_active,
  output logic             rx_overflow
);

  rx_cfg_t    cfg_q;
  logic       cfg_unused;
  logic [2:0] line_s;
  logic       tick, full;
  logic       emit_v, emit_right;
  logic [SAMPLE_W-1:0] emit_sample;
  logic       flush_req, rx_rst_req;
  logic [1:0] stop_mode_q;

  assign cfg_unused = ^cfg_word[31:CFG_USED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= rx_cfg_t'(CFG_RESET);
    else        cfg_q <= rx_cfg_t'(cfg_word[CFG_USED-1:0]);
  end

  assign flush_req   = cfg_q.flush;
  assign rx_rst_req  = cfg_q.rx_rst;
  assign stop_mode_q = cfg_q.stop_mode;

  i2s_slot_rx_sync #(.STAGES(SYNC_STAGES), .LINES(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sd_in, ws_in, bclk_in}),
    .dout  (line_s),
    .rise0 (tick)
  );

  i2s_slot_rx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_q.run),
    .rx_rst    (cfg_q.rx_rst),
    .stop_mode (cfg_q.stop_mode),
    .eof       (eof_in),
    .full      (full),
    .active    (rx_active)
  );

  i2s_slot_rx_deser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (cfg_q.rx_rst),
    .active      (rx_active),
    .tick        (tick),
    .ws          (line_s[1]),
    .sd          (line_s[2]),
    .lsb_first   (cfg_q.lsb_first),
    .left_just   (cfg_q.left_just),
    .ws_pol      (cfg_q.ws_pol),
    .emit_v      (emit_v),
    .emit_right  (emit_right),
    .emit_sample (emit_sample)
  );

  i2s_slot_rx_out #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (cfg_q.flush),
    .emit_v      (emit_v),
    .emit_right  (emit_right),
    .emit_sample (emit_sample),
    .mono        (cfg_q.mono),
    .mono_first  (cfg_q.mono_first),
    .fill_wide   (cfg_q.fill_wide),
    .stop_mode   (cfg_q.stop_mode),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_right   (out_right),
    .overflow    (rx_overflow),
    .full        (full)
  );

endmodule

// File: rtl/i2s_slot_rx_chk.sv
module i2s_slot_rx_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OUT_W-1:0] out_data,
  input logic             out_right,
  input logic             out_valid,
  input logic             out_ready,
  input logic             rx_active,
  input logic             rx_overflow,
  input logic             eof_in,
  input logic             flush_req,
  input logic             rx_rst_req,
  input logic [1:0]       stop_mode
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush_req |=>
      out_valid && $stable(out_data) && $stable(out_right));

  p_start_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rx_active, 2));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow && !flush_req |=> rx_overflow);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overflow) |-> $past(stop_mode) != 2'd2);

  p_full_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active && stop_mode == 2'd2 && out_valid && !out_ready |=> !rx_active);

  p_eof_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active && stop_mode == 2'd1 && eof_in |=> !rx_active);

  p_rst_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_req |=> !rx_active);

  p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !out_valid && !rx_overflow);

endmodule

bind i2s_slot_rx i2s_slot_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_data    (out_data),
  .out_right   (out_right),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .rx_active   (rx_active),
  .rx_overflow (rx_overflow),
  .eof_in      (eof_in),
  .flush_req   (flush_req),
  .rx_rst_req  (rx_rst_req),
  .stop_mode   (stop_mode_q)
);

// File: tb/i2s_slot_rx_bench.sv
`timescale 1ns/1ps
module i2s_slot_rx_bench;

  localparam int SW   = 24;
  localparam int SLOT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic        bclk = 1'b0, ws = 1'b0, sd = 1'b0, eof = 1'b0;
  logic [31:0] out_data;
  logic        out_right, out_valid, rx_active, rx_overflow;
  logic        out_ready = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  logic [32:0] exp_q[$];

  always #2 clk = ~clk;

  i2s_slot_rx u_i2s_slot_rx (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .bclk_in(bclk), .ws_in(ws),
    .sd_in(sd), .eof_in(eof), .out_data(out_data), .out_right(out_right),
    .out_valid(out_valid), .out_ready(out_ready), .rx_active(rx_active),
    .rx_overflow(rx_overflow)
  );

  task automatic check(input logic ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // monitor: scoreboard pop on every handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R11 unexpected word", {out_right, out_data}, 33'h0);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        check({out_right, out_data} == e, "R1/R2/R3/R4/R5/R6 word", {out_right, out_data}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 33'h0, 33'h1);
    finish_run();
  end

  function automatic logic [31:0] mk_cfg(input logic run, input logic rst, input logic fl,
      input logic mono, input logic mfirst, input logic pol, input logic lsb,
      input logic left, input logic fill, input logic [1:0] stop);
    return {21'h0, stop, fill, left, lsb, pol, mfirst, mono, fl, rst, run};
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [31:0] c);
    @(posedge clk); #1 cfg_word = c;
    wait_clks(3);
  endtask

  task automatic drive_bit(input logic w, input logic d);
    @(posedge clk); #1;
    bclk = 1'b0; ws = w; sd = d;
    repeat (3) @(posedge clk);
    #1 bclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_slot(input logic w, input logic nw, input logic [SW-1:0] s,
                           input logic lsb, input logic left);
    for (int k = 0; k < SLOT; k++) begin
      int   idx;
      logic b;
      idx = left ? k : k - (SLOT - SW);
      if (idx >= 0 && idx < SW) b = lsb ? s[idx] : s[SW-1-idx];
      else                      b = 1'($urandom % 2);
      drive_bit((k == SLOT - 1) ? nw : w, b);
    end
  endtask

  // a partial lead-in slot, then n full slots; first n_acc kept slots are expected
  task automatic stream(input int n, input int n_acc, input logic mono, input logic mfirst,
                        input logic pol, input logic lsb, input logic left, input logic fill);
    int   acc;
    logic w;
    acc = 0;
    w = ws;
    send_slot(w, ~w, 24'h5A5A5A, lsb, left);
    for (int i = 0; i < n; i++) begin
      logic [SW-1:0] s;
      logic          r;
      w = ~w;
      s = SW'($urandom);
      s[SW-1] = i[0];
      r = w ^ pol;
      if ((!mono || (r == !mfirst)) && acc < n_acc) begin
        exp_q.push_back({r, fill ? {{8{s[SW-1]}}, s} : {8'h00, s}});
        acc++;
      end
      send_slot(w, ~w, s, lsb, left);
    end
  endtask

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(2);
    check(out_valid == 1'b0, "R11 reset valid", {32'h0, out_valid}, 33'h0);
    check(rx_active == 1'b0, "R11 reset active", {32'h0, rx_active}, 33'h0);
    check(rx_overflow == 1'b0, "R8 reset overflow", {32'h0, rx_overflow}, 33'h0);

    // R11: idle after reset delivers nothing
    stream(3, 0, 0, 1, 0, 0, 1, 0);
    wait_clks(20);
    check(out_valid == 1'b0 && exp_q.size() == 0, "R11 idle no output", {32'h0, out_valid}, 33'h0);

    // R2/R3/R5 sweep with R4/R6 variants
    for (int c = 0; c < 8; c++) begin
      logic pol, lsb, mono, mf, left, fill;
      pol = c[0]; lsb = c[1]; mono = c[2];
      mf = c[0] ^ c[1]; left = c[1] ^ c[2]; fill = ~c[0] ^ c[2];
      set_cfg(mk_cfg(0, 0, 0, mono, mf, pol, lsb, left, fill, 2'd0));
      set_cfg(mk_cfg(1, 0, 0, mono, mf, pol, lsb, left, fill, 2'd0));
      check(rx_active == 1'b1, "R11 start", {32'h0, rx_active}, 33'h1);
      stream(4, 4, mono, mf, pol, lsb, left, fill);
      wait_clks(30);
      check(exp_q.size() == 0, "R2/R3/R4/R5/R6 all words seen", 33'(exp_q.size()), 33'h0);
      set_cfg(mk_cfg(0, 0, 0, mono, mf, pol, lsb, left, fill, 2'd0));
      check(rx_active == 1'b0, "R11 run cleared", {32'h0, rx_active}, 33'h0);
    end

    // R8 overflow under back-pressure, then R13 flush
    out_ready = 1'b0;
    set_cfg(mk_cfg(1, 0, 0, 0, 1, 0, 0, 1, 0, 2'd0));
    stream(3, 1, 0, 1, 0, 0, 1, 0);
    wait_clks(20);
    check(out_valid == 1'b1, "R7 word held", {32'h0, out_valid}, 33'h1);
    check({out_right, out_data} == exp_q[0], "R7 held data", {out_right, out_data}, exp_q[0]);
    check(rx_overflow == 1'b1, "R8 overflow set", {32'h0, rx_overflow}, 33'h1);
    set_cfg(mk_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0, 2'd0));
    check(rx_overflow == 1'b1, "R8 overflow sticky", {32'h0, rx_overflow}, 33'h1);
    set_cfg(mk_cfg(0, 0, 1, 0, 1, 0, 0, 1, 0, 2'd0));
    set_cfg(mk_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0, 2'd0));
    check(out_valid == 1'b0 && rx_overflow == 1'b0, "R13 flush",
          {31'h0, out_valid, rx_overflow}, 33'h0);
    exp_q.delete();
    out_ready = 1'b1;
    wait_clks(5);

    // R10 stop on full
    out_ready = 1'b0;
    set_cfg(mk_cfg(1, 0, 0, 0, 1, 0, 0, 1, 0, 2'd2));
    stream(3, 1, 0, 1, 0, 0, 1, 0);
    wait_clks(20);
    check(rx_active == 1'b0, "R10 stopped on full", {32'h0, rx_active}, 33'h0);
    check(rx_overflow == 1'b0, "R10 no overflow", {32'h0, rx_overflow}, 33'h0);
    out_ready = 1'b1;
    wait_clks(20);
    check(exp_q.size() == 0, "R10 held word delivered", 33'(exp_q.size()), 33'h0);
    check(rx_active == 1'b0, "R11 no restart without toggle", {32'h0, rx_active}, 33'h0);
    set_cfg(mk_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0, 2'd2));

    // R9 stop on end-of-frame
    set_cfg(mk_cfg(1, 0, 0, 0, 1, 1, 1, 0, 1, 2'd1));
    stream(2, 2, 0, 1, 1, 1, 0, 1);
    wait_clks(20);
    @(posedge clk); #1 eof = 1'b1;
    @(posedge clk); #1 eof = 1'b0;
    wait_clks(2);
    check(rx_active == 1'b0, "R9 stopped on eof", {32'h0, rx_active}, 33'h0);
    stream(2, 0, 0, 1, 1, 1, 0, 1);
    wait_clks(20);
    check(exp_q.size() == 0 && out_valid == 1'b0, "R9 nothing after eof",
          33'(exp_q.size()), 33'h0);
    set_cfg(mk_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0, 2'd0));

    // R12 receiver reset
    set_cfg(mk_cfg(1, 0, 0, 0, 1, 0, 0, 1, 0, 2'd0));
    check(rx_active == 1'b1, "R12 active before reset", {32'h0, rx_active}, 33'h1);
    set_cfg(mk_cfg(1, 1, 0, 0, 1, 0, 0, 1, 0, 2'd0));
    check(rx_active == 1'b0, "R12 reset idles", {32'h0, rx_active}, 33'h0);
    stream(2, 0, 0, 1, 0, 0, 1, 0);
    wait_clks(20);
    check(out_valid == 1'b0, "R12 no output in reset", {32'h0, out_valid}, 33'h0);
    set_cfg(mk_cfg(1, 0, 0, 0, 1, 0, 0, 1, 0, 2'd0));
    check(rx_active == 1'b0, "R11 reset release needs toggle", {32'h0, rx_active}, 33'h0);

    finish_run();
  end

endmodule